// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver with Vote-Based Noise Detection

This block recovers asynchronous serial frames from a single line. The line is sampled only on pulses of an external oversample tick, sixteen per bit period. The value of each bit is the two-out-of-three vote of samples 8, 9 and 10 of that bit. If those three samples do not all agree, the voted value is still accepted, but the frame is marked noisy. The sample count restarts at every start-bit edge, so clock error builds up only within one frame.

Two configuration bits select the payload. One picks a long or short word. The other picks whether the last payload bit is a parity bit. The four formats are:
- 8 data bits.
- 7 data bits plus parity.
- 9 data bits.
- 8 data bits plus parity.

With parity enabled, the receiver checks for an even or odd count of ones. It raises a sticky parity-error flag and, if enabled, an interrupt. A low stop bit sets a sticky framing-error flag. All flags stay set until the clear input is pulsed.

Top module: `uart_os_rx`

## Requirements
- R1: After synchronous reset, rx_valid, rx_data, noise_flag, parity_err, frame_err and irq are all 0, and the line is treated as idle high.
- R2: Sample 1 of the start bit is the first os_tick that sees the line low while idle. Every bit lasts 16 ticks. A bit's value is the majority of its samples 8, 9 and 10.
- R3: If samples 8, 9 and 10 of any bit disagree (start, data, parity or stop bit), noise_flag is set in the same cycle that rx_valid is raised for that frame. The data still takes the majority value.
- R4: If the start bit votes high, the receiver returns to idle without raising rx_valid or touching any flag. The next low tick begins a new frame.
- R5: Bits arrive least significant first into rx_data[0] upward. With cfg_word9=0 there are 8 payload bits and rx_data[8] is 0. With cfg_word9=1 there are 9 payload bits. With parity enabled, the parity bit is the top payload bit: rx_data[7] for short words and rx_data[8] for long words.
- R6: With cfg_par_en=1, parity_err is set when the XOR of all payload bits (data plus parity) differs from cfg_par_odd. Here 0 means even and 1 means odd. With cfg_par_en=0, parity_err is never set.
- R7: irq is set together with parity_err only when cfg_par_irq_en=1. irq is never 1 while parity_err is 0.
- R8: If the stop bit votes low, frame_err is set. The data is still delivered with rx_valid.
- R9: rx_valid is a one-cycle pulse per accepted frame. It is raised on the clock after the tick of stop-bit sample 10. The receiver can accept a new start bit on the very next tick.
- R10: noise_flag, parity_err, frame_err and irq hold until flag_clr is pulsed, which clears all four. If a new frame sets a flag in the same cycle as the clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_word9 | input | 1 | 1 selects a 9-bit payload, 0 an 8-bit payload |
| cfg_par_en | input | 1 | Top payload bit is a parity bit |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_par_irq_en | input | 1 | Allow parity error to raise irq |
| flag_clr | input | 1 | Clears all sticky flags |
| rx_data | output | 9 | Last received payload |
| rx_valid | output | 1 | One-cycle strobe for a new payload |
| noise_flag | output | 1 | Sticky: a voted sample triple disagreed |
| parity_err | output | 1 | Sticky parity mismatch |
| frame_err | output | 1 | Sticky low stop bit |
| irq | output | 1 | Sticky parity interrupt |

## Verification
The bench injects a single flipped sample at position 8, 9 or 10 into a start bit, a data bit, a parity bit and a stop bit. A receiver that used one centre sample would corrupt the data or report a false framing error. One that skipped noise tracking on some bit would leave noise_flag clear.

A start pulse that is low for only six samples must be rejected. Otherwise a spurious frame would appear.

A frame whose stop bit lasts just 11 samples is followed at once by the next start bit. A receiver that waits for a full stop bit would miss or misalign the second frame.

Parity is exercised in all four formats with both polarities. Sticky behaviour is checked by a clean frame that follows an errored one without a clear.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rx_vote.sv
module rx_vote
  import uart_os_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic launch,
  input  logic active,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_noise
);

  localparam int CW = $clog2(OVS);
  // The counter holds the number of samples already taken in this bit.
  localparam logic [CW-1:0] TAKE_A = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] TAKE_B = CW'(OVS / 2);
  localparam logic [CW-1:0] TAKE_C = CW'(OVS / 2 + 1);

  logic [CW-1:0] cnt;
  logic          smp_a, smp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else if (launch) begin
      cnt <= CW'(1);
    end else if (!active) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CW'(1);
      if (cnt == TAKE_A) smp_a <= line;
      if (cnt == TAKE_B) smp_b <= line;
    end
  end

  assign bit_stb   = active & tick & (cnt == TAKE_C);
  assign bit_val   = vote3(smp_a, smp_b, line);
  assign bit_noise = !((smp_a == smp_b) && (smp_b == line));

endmodule

// File: rtl/rx_parity.sv
module rx_parity #(
  parameter int DW = 9
) (
  input  logic [DW-1:0] payload,
  input  logic          long_word,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          par_bad
);

  logic [DW-1:0] mask;
  logic          ones_odd;

  always_comb begin
    mask     = long_word ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
    ones_odd = ^(payload & mask);
    par_bad  = par_en & (ones_odd != par_odd);
  end

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line,
  input  logic          long_word,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic          bit_noise,
  input  logic          par_bad,
  input  logic          par_irq_en,
  input  logic          flag_clr,
  output logic          launch,
  output logic          active,
  output logic [DW-1:0] shreg,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          noise_flag,
  output logic          parity_err,
  output logic          frame_err,
  output logic          irq
);

  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] LAST_LONG  = IW'(DW - 1);
  localparam logic [IW-1:0] LAST_SHORT = IW'(DW - 2);

  rx_state_t     state;
  logic [IW-1:0] idx;
  logic          noise_acc;
  logic [IW-1:0] last_idx;

  assign launch   = (state == RX_IDLE) & tick & !line;
  assign active   = (state != RX_IDLE);
  assign last_idx = long_word ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      idx        <= '0;
      shreg      <= '0;
      noise_acc  <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      noise_flag <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (flag_clr) begin
        noise_flag <= 1'b0;
        parity_err <= 1'b0;
        frame_err  <= 1'b0;
        irq        <= 1'b0;
      end
      unique case (state)
        RX_IDLE: begin
          if (launch) begin
            state     <= RX_START;
            shreg     <= '0;
            idx       <= '0;
            noise_acc <= 1'b0;
          end
        end
        RX_START: begin
          if (bit_stb) begin
            if (bit_val) begin
              state <= RX_IDLE;
            end else begin
              state     <= RX_DATA;
              noise_acc <= bit_noise;
            end
          end
        end
        RX_DATA: begin
          if (bit_stb) begin
            shreg[idx] <= bit_val;
            noise_acc  <= noise_acc | bit_noise;
            if (idx == last_idx) state <= RX_STOP;
            else                 idx   <= idx + IW'(1);
          end
        end
        RX_STOP: begin
          if (bit_stb) begin
            state    <= RX_IDLE;
            rx_valid <= 1'b1;
            rx_data  <= shreg;
            if (noise_acc | bit_noise)  noise_flag <= 1'b1;
            if (!bit_val)               frame_err  <= 1'b1;
            if (par_bad)                parity_err <= 1'b1;
            if (par_bad && par_irq_en)  irq        <= 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OVS         = 16,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          cfg_word9,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_par_irq_en,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          noise_flag,
  output logic          parity_err,
  output logic          frame_err,
  output logic          irq
);

  logic          line;
  logic          launch, active;
  logic          bit_stb, bit_val, bit_noise;
  logic          par_bad;
  logic [DW-1:0] shreg;

  rx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (line)
  );

  rx_vote #(.OVS(OVS)) u_vote (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .line      (line),
    .launch    (launch),
    .active    (active),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .bit_noise (bit_noise)
  );

  rx_parity #(.DW(DW)) u_par (
    .payload   (shreg),
    .long_word (cfg_word9),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .par_bad   (par_bad)
  );

  rx_frame #(.DW(DW)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .line       (line),
    .long_word  (cfg_word9),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .bit_noise  (bit_noise),
    .par_bad    (par_bad),
    .par_irq_en (cfg_par_irq_en),
    .flag_clr   (flag_clr),
    .launch     (launch),
    .active     (active),
    .shreg      (shreg),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .noise_flag (noise_flag),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .irq        (irq)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic clk,
  input logic rst,
  input logic par_en,
  input logic flag_clr,
  input logic rx_valid,
  input logic noise_flag,
  input logic parity_err,
  input logic frame_err,
  input logic irq
);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_irq_implies_pe_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> parity_err);

  p_noise_with_valid_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(noise_flag) |-> rx_valid);

  p_fe_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> rx_valid);

  p_pe_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(parity_err) |-> $past(par_en));

  p_noise_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (noise_flag && !flag_clr) |=> noise_flag);

  p_pe_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (parity_err && !flag_clr) |=> parity_err);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (!frame_err || rx_valid));

endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .par_en     (cfg_par_en),
  .flag_clr   (flag_clr),
  .rx_valid   (rx_valid),
  .noise_flag (noise_flag),
  .parity_err (parity_err),
  .frame_err  (frame_err),
  .irq        (irq)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_word9 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_par_irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid, noise_flag, parity_err, frame_err, irq;

  always #2.5 clk = ~clk;

  uart_os_rx u0 (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .cfg_word9(cfg_word9), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_par_irq_en(cfg_par_irq_en), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .noise_flag(noise_flag),
    .parity_err(parity_err), .frame_err(frame_err), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [8:0] last_data = '0, prev_data = '0;

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount    = vcount + 1;
      prev_data = last_data;
      last_data = rx_data;
    end
  end

  typedef struct packed {
    logic       w9, pen, podd, ie;
    logic [8:0] pay;
    logic       stopv;
    logic [3:0] gidx;
    logic [2:0] gm;
    logic       ne, fe, pe, iq;
  } vec_t;

  // gidx: 0 start bit, 1..n data bit n-1, n+1 stop bit, 15 none. gm flips samples {10,9,8}.
  localparam vec_t VECS [12] = '{
    '{1'b0,1'b0,1'b0,1'b1, 9'h0A5, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b1, 9'h035, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1, 9'h035, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b1,1'b1, 9'h0B5, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1, 9'h1C3, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0, 9'h1FF, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,1'b1, 9'h1FF, 1'b1, 4'd15, 3'b000, 1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 9'h055, 1'b0, 4'd15, 3'b000, 1'b0,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 9'h0F0, 1'b1, 4'd3,  3'b001, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1, 9'h101, 1'b1, 4'd9,  3'b010, 1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 9'h03C, 1'b1, 4'd9,  3'b100, 1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 9'h0C3, 1'b1, 4'd0,  3'b010, 1'b1,1'b0,1'b0,1'b0}
  };

  vec_t cur;
  int   base;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic gbit(input int s, input logic [2:0] m);
    return (s == 8) ? m[0] : (s == 9) ? m[1] : (s == 10) ? m[2] : 1'b0;
  endfunction

  task automatic send_sample(input logic v);
    @(negedge clk) rxd = v;
    repeat (2) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input logic [2:0] m);
    for (int s = 1; s <= 16; s++) send_sample(v ^ gbit(s, m));
  endtask

  task automatic send_frame(input logic [8:0] pay, input int npay, input logic stopv,
                            input int gidx, input logic [2:0] gm, input int stop_len, input int tail);
    send_bit(1'b0, (gidx == 0) ? gm : 3'b000);
    for (int i = 0; i < npay; i++) send_bit(pay[i], (gidx == i + 1) ? gm : 3'b000);
    for (int s = 1; s <= stop_len; s++)
      send_sample(stopv ^ gbit(s, (gidx == npay + 1) ? gm : 3'b000));
    repeat (tail) send_bit(1'b1, 3'b000);
  endtask

  task automatic pulse_clear();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "rx_data", rx_data, 0);
    chk("R1", "flags", {noise_flag, parity_err, frame_err, irq}, 0);

    // table walk: R2 R3 R5 R6 R7 R8 R9
    for (int k = 0; k < 12; k++) begin
      cur = VECS[k];
      cfg_word9 = cur.w9; cfg_par_en = cur.pen; cfg_par_odd = cur.podd; cfg_par_irq_en = cur.ie;
      pulse_clear();
      base = vcount;
      send_frame(cur.pay, cur.w9 ? 9 : 8, cur.stopv, int'(cur.gidx), cur.gm, 16, 2);
      chk("R9", $sformatf("vec%0d one valid", k), vcount - base, 1);
      chk("R5", $sformatf("vec%0d data", k), last_data, cur.w9 ? cur.pay : {1'b0, cur.pay[7:0]});
      chk("R3", $sformatf("vec%0d noise", k), noise_flag, cur.ne);
      chk("R8", $sformatf("vec%0d frame_err", k), frame_err, cur.fe);
      chk("R6", $sformatf("vec%0d parity_err", k), parity_err, cur.pe);
      chk("R7", $sformatf("vec%0d irq", k), irq, cur.iq);
    end

    // R4 false start: low for only 6 samples
    cfg_word9 = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_par_irq_en = 1'b1;
    pulse_clear();
    base = vcount;
    for (int s = 1; s <= 16; s++) send_sample(s > 6);
    send_bit(1'b1, 3'b000);
    chk("R4", "no frame after short start", vcount - base, 0);
    chk("R4", "flags untouched", {noise_flag, parity_err, frame_err, irq}, 0);
    send_frame(9'h05A, 8, 1'b1, 15, 3'b000, 16, 1);
    chk("R4", "frame after rejected start", last_data, 9'h05A);

    // R9 resync: stop lasts 11 samples, next start follows at once
    base = vcount;
    send_frame(9'h0E1, 8, 1'b1, 15, 3'b000, 11, 0);
    send_frame(9'h01E, 8, 1'b1, 15, 3'b000, 16, 1);
    chk("R9", "two frames back to back", vcount - base, 2);
    chk("R9", "first back-to-back data", prev_data, 9'h0E1);
    chk("R9", "second back-to-back data", last_data, 9'h01E);
    chk("R2", "no false error on short stop", frame_err, 0);

    // R10 sticky then clear
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    pulse_clear();
    send_frame(9'h035, 8, 1'b1, 15, 3'b000, 16, 1);
    cfg_par_en = 1'b0;
    send_frame(9'h0A5, 8, 1'b1, 15, 3'b000, 16, 1);
    chk("R10", "parity_err held", parity_err, 1);
    chk("R10", "irq held", irq, 1);
    chk("R10", "clean data", last_data, 9'h0A5);
    pulse_clear();
    chk("R10", "cleared flags", {noise_flag, parity_err, frame_err, irq}, 0);

    finish_run();
  end

endmodule